// File: doc/BRIEF.md
# Radio transmit start sequencer

This block owns the host-controlled transmit-start bit of a packet radio MAC and runs one transmit operation per start. It can wake the radio out of a low-power state first. It then runs an optional channel-access step with collision avoidance. After that it sends the frame and can wait for an acknowledgement, resending the frame when the wait times out. The channel-access, transmitter and acknowledgement-detect engines sit outside the block. The sequencer starts each engine with a one-cycle strobe and waits for its done signal. The outcome of each operation is reported through sticky flags, which the host clears by writing 1.

The start bit reads 1 while an operation is in progress. When the operation finishes, hardware clears the bit. A host write of 0 aborts the operation in any phase. In streaming mode, a second write of 1 during an operation queues one further start. That start is launched in the cycle after the current operation finishes.

Top module: `tx_start_seq`

## Requirements
- R1: While reset is asserted, start_o, flags_o, wake_req_o, csma_go_o, tx_go_o, ack_listen_o and abort_o are all 0.
- R2: Writing 1 to the start bit while it reads 0 makes start_o 1 after that clock edge. If rf_off_i is low, the first phase strobe (csma_go_o, or tx_go_o when channel access is disabled) is high in that same cycle.
- R3: When csma_en_i is 0, csma_go_o never rises and the operation goes straight to tx_go_o.
- R4: The flag bits are fixed: bit 0 is done, bit 1 is idle, bit 2 is channel-access failure and bit 3 is acknowledgement failure. A successful finish with no queued start clears start_o and sets flags 0 and 1 at the same edge.
- R5: A channel-access result of failure (csma_done_i=1, csma_ok_i=0) clears start_o, sets flag 2 and starts no send.
- R6: After tx_done_i, the block waits for an acknowledgement only when both ack_req_i and auto_ack_en_i are 1. During the wait, ack_listen_o is high. An ack_rx_i received during the wait is a success.
- R7: A wait with no acknowledgement lasts ack_timeout_i cycles, or 1 cycle when ack_timeout_i is 0. The frame is then resent (through channel access if it is enabled) while the number of retries is below retry_limit_i. After retry_limit_i+1 sends with no acknowledgement, start_o clears and flag 3 is set.
- R8: In streaming mode, writing 1 while start_o is 1 queues one start. When the operation finishes, start_o stays 1, the outcome flag is set (flag 0 is set without flag 1 on success), and the first phase strobe follows at once with the retry count reset to zero.
- R9: Outside streaming mode, writing 1 while start_o is 1 is ignored, and start_o clears when the operation finishes.
- R10: Writing 0 while start_o is 1 aborts the operation in the wake, channel-access, send or acknowledgement-wait phase. start_o clears and abort_o pulses high for the next cycle. No flag is set, any queued start is dropped, and no further strobe follows.
- R11: A start written while rf_off_i is 1 raises wake_req_o and holds back all phase strobes until rf_off_i falls. The first phase strobe comes in the cycle after it falls.
- R12: Each flag stays set until the host writes 1 to its bit of flag_clr_i. A clear in the same cycle as a set of that flag loses to the set.
- R13: A host write of 0 in the cycle an operation finishes wins: no flag is set. A streaming write of 1 in that cycle acts as a queued start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_we_i | input | 1 | Host write strobe for the start bit |
| start_wdata_i | input | 1 | Value written to the start bit |
| start_o | output | 1 | Start bit readback; 1 while an operation is in progress |
| flag_clr_i | input | 4 | Write-1-to-clear strobes for the flags |
| flags_o | output | 4 | Sticky flags: done, idle, channel-access failure, acknowledgement failure |
| stream_mode_i | input | 1 | Streaming mode; allows one queued start |
| csma_en_i | input | 1 | Enables the channel-access phase |
| ack_req_i | input | 1 | The frame asks for an acknowledgement |
| auto_ack_en_i | input | 1 | Automatic acknowledgement handling is enabled |
| retry_limit_i | input | RETRY_W | Maximum number of resends |
| ack_timeout_i | input | TMO_W | Length of the acknowledgement wait, in cycles |
| rf_off_i | input | 1 | Radio is in sleep or RF-off state |
| wake_req_o | output | 1 | Request to bring the radio into the transmit state |
| csma_go_o | output | 1 | Start strobe for the channel-access engine |
| csma_done_i | input | 1 | Channel-access engine has finished |
| csma_ok_i | input | 1 | Channel-access result, valid with csma_done_i |
| tx_go_o | output | 1 | Start strobe for the transmitter |
| tx_done_i | input | 1 | Transmitter has finished the frame |
| ack_listen_o | output | 1 | Acknowledgement wait is active |
| ack_rx_i | input | 1 | A matching acknowledgement was detected |
| abort_o | output | 1 | One-cycle pulse telling the engines to stop |

## Verification
A host write to the start bit and the hardware finish of an operation can land in the same cycle. The bench provokes this by driving start_we_i together with tx_done_i. With a written 0, the abort must win: start_o reads 0, abort_o pulses and flags_o stays clear. With a written 1 in streaming mode, start_o must stay 1, only the done flag may be set, and tx_go_o must fire in the next cycle. A flag clear driven in the same cycle as a finish is judged in the same way, by the flags left set afterwards.

// File: rtl/tx_start_pkg.sv
package tx_start_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAKE,
    PH_CSMA,
    PH_SEND,
    PH_ACKW
  } phase_e;

  typedef enum logic [1:0] {
    OUT_OK,
    OUT_CSMA_FAIL,
    OUT_ACK_FAIL
  } outcome_e;

  localparam int unsigned FLAG_N    = 4;
  localparam int unsigned FLAG_DONE = 0;
  localparam int unsigned FLAG_IDLE = 1;
  localparam int unsigned FLAG_CSMA = 2;
  localparam int unsigned FLAG_ACK  = 3;
endpackage

// File: rtl/tx_start_ctl.sv
module tx_start_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wdata_i,
  input  logic stream_i,
  input  logic fin_i,
  output logic start_o,
  output logic launch_o,
  output logic abort_o,
  output logic post_pend_o
);
  logic start_q, posted_q;
  logic host_set, host_clr, post_req;

  assign host_set    = we_i & wdata_i;
  assign host_clr    = we_i & ~wdata_i;
  assign abort_o     = host_clr & start_q;
  assign launch_o    = host_set & ~start_q;
  // a second start is only queued in streaming mode, one deep
  assign post_req    = host_set & start_q & stream_i & ~posted_q;
  assign post_pend_o = posted_q | post_req;
  assign start_o     = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      posted_q <= 1'b0;
    end else if (abort_o) begin
      start_q  <= 1'b0;
      posted_q <= 1'b0;
    end else if (launch_o) begin
      start_q  <= 1'b1;
    end else if (fin_i) begin
      start_q  <= post_pend_o;
      posted_q <= 1'b0;
    end else if (post_req) begin
      posted_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_phase_fsm.sv
module tx_phase_fsm
  import tx_start_pkg::*;
#(
  parameter int unsigned RETRY_W = 3,
  parameter int unsigned TMO_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic               abort_i,
  input  logic               post_pend_i,
  input  logic               rf_off_i,
  input  logic               csma_en_i,
  input  logic               ack_en_i,
  input  logic [RETRY_W-1:0] retry_limit_i,
  input  logic [TMO_W-1:0]   ack_tmo_i,
  input  logic               csma_done_i,
  input  logic               csma_ok_i,
  input  logic               tx_done_i,
  input  logic               ack_rx_i,
  output logic               fin_o,
  output outcome_e           outcome_o,
  output logic               wake_req_o,
  output logic               csma_go_o,
  output logic               tx_go_o,
  output logic               ack_listen_o
);
  localparam int unsigned TW = TMO_W + 1;

  phase_e             ph_q, ph_d, first_ph;
  logic               enter_q, enter_d;
  logic [RETRY_W-1:0] rty_q, rty_d;
  logic [TMO_W-1:0]   tmr_q, tmr_d;
  logic [TW-1:0]      tmr_inc;
  logic               tmo_hit, rty_more, fin_raw;
  outcome_e           out_d;

  assign first_ph = csma_en_i ? PH_CSMA : PH_SEND;
  assign tmr_inc  = {1'b0, tmr_q} + TW'(1);
  // a zero timeout behaves as one cycle
  assign tmo_hit  = tmr_inc >= {1'b0, ack_tmo_i};
  assign rty_more = rty_q < retry_limit_i;

  always_comb begin
    ph_d    = ph_q;
    enter_d = 1'b0;
    rty_d   = rty_q;
    tmr_d   = tmr_q;
    fin_raw = 1'b0;
    out_d   = OUT_OK;
    unique case (ph_q)
      PH_IDLE: if (launch_i) begin
        ph_d    = rf_off_i ? PH_WAKE : first_ph;
        enter_d = 1'b1;
        rty_d   = '0;
      end
      PH_WAKE: if (!rf_off_i) begin
        ph_d    = first_ph;
        enter_d = 1'b1;
      end
      PH_CSMA: if (csma_done_i) begin
        if (csma_ok_i) begin
          ph_d    = PH_SEND;
          enter_d = 1'b1;
        end else begin
          fin_raw = 1'b1;
          out_d   = OUT_CSMA_FAIL;
        end
      end
      PH_SEND: if (tx_done_i) begin
        if (ack_en_i) begin
          ph_d    = PH_ACKW;
          enter_d = 1'b1;
          tmr_d   = '0;
        end else begin
          fin_raw = 1'b1;
        end
      end
      PH_ACKW: begin
        if (ack_rx_i) begin
          fin_raw = 1'b1;
        end else if (tmo_hit) begin
          if (rty_more) begin
            rty_d   = rty_q + RETRY_W'(1);
            ph_d    = first_ph;
            enter_d = 1'b1;
          end else begin
            fin_raw = 1'b1;
            out_d   = OUT_ACK_FAIL;
          end
        end else begin
          tmr_d = tmr_inc[TMO_W-1:0];
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (fin_raw) begin
      if (post_pend_i) begin
        ph_d    = first_ph;
        enter_d = 1'b1;
        rty_d   = '0;
      end else begin
        ph_d = PH_IDLE;
      end
    end
    if (abort_i) begin
      ph_d    = PH_IDLE;
      enter_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      enter_q <= 1'b0;
      rty_q   <= '0;
      tmr_q   <= '0;
    end else begin
      ph_q    <= ph_d;
      enter_q <= enter_d;
      rty_q   <= rty_d;
      tmr_q   <= tmr_d;
    end
  end

  assign fin_o        = fin_raw & ~abort_i;
  assign outcome_o    = out_d;
  assign wake_req_o   = (ph_q == PH_WAKE);
  assign ack_listen_o = (ph_q == PH_ACKW);
  assign csma_go_o    = (ph_q == PH_CSMA) & enter_q;
  assign tx_go_o      = (ph_q == PH_SEND) & enter_q;
endmodule

// File: rtl/tx_irq_flags.sv
module tx_irq_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (set_i[i]) f_q <= 1'b1;
      else if (clr_i[i]) f_q <= 1'b0;
    end
    assign flags_o[i] = f_q;
  end
endmodule

// File: rtl/tx_start_seq.sv
module tx_start_seq
  import tx_start_pkg::*;
#(
  parameter int unsigned RETRY_W = 3,
  parameter int unsigned TMO_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_we_i,
  input  logic               start_wdata_i,
  output logic               start_o,
  input  logic [FLAG_N-1:0]  flag_clr_i,
  output logic [FLAG_N-1:0]  flags_o,
  input  logic               stream_mode_i,
  input  logic               csma_en_i,
  input  logic               ack_req_i,
  input  logic               auto_ack_en_i,
  input  logic [RETRY_W-1:0] retry_limit_i,
  input  logic [TMO_W-1:0]   ack_timeout_i,
  input  logic               rf_off_i,
  output logic               wake_req_o,
  output logic               csma_go_o,
  input  logic               csma_done_i,
  input  logic               csma_ok_i,
  output logic               tx_go_o,
  input  logic               tx_done_i,
  output logic               ack_listen_o,
  input  logic               ack_rx_i,
  output logic               abort_o
);
  logic        launch, abort, post_pend, fin;
  outcome_e    outcome;
  logic [FLAG_N-1:0] flag_set;
  logic        abort_q;

  tx_start_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (start_we_i),
    .wdata_i     (start_wdata_i),
    .stream_i    (stream_mode_i),
    .fin_i       (fin),
    .start_o     (start_o),
    .launch_o    (launch),
    .abort_o     (abort),
    .post_pend_o (post_pend)
  );

  tx_phase_fsm #(
    .RETRY_W (RETRY_W),
    .TMO_W   (TMO_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_i      (launch),
    .abort_i       (abort),
    .post_pend_i   (post_pend),
    .rf_off_i      (rf_off_i),
    .csma_en_i     (csma_en_i),
    .ack_en_i      (ack_req_i & auto_ack_en_i),
    .retry_limit_i (retry_limit_i),
    .ack_tmo_i     (ack_timeout_i),
    .csma_done_i   (csma_done_i),
    .csma_ok_i     (csma_ok_i),
    .tx_done_i     (tx_done_i),
    .ack_rx_i      (ack_rx_i),
    .fin_o         (fin),
    .outcome_o     (outcome),
    .wake_req_o    (wake_req_o),
    .csma_go_o     (csma_go_o),
    .tx_go_o       (tx_go_o),
    .ack_listen_o  (ack_listen_o)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_DONE] = fin & (outcome == OUT_OK);
    // idle only when no queued start takes over
    flag_set[FLAG_IDLE] = fin & (outcome == OUT_OK) & ~post_pend;
    flag_set[FLAG_CSMA] = fin & (outcome == OUT_CSMA_FAIL);
    flag_set[FLAG_ACK]  = fin & (outcome == OUT_ACK_FAIL);
  end

  tx_irq_flags #(
    .N (FLAG_N)
  ) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (flag_clr_i),
    .flags_o (flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) abort_q <= 1'b0;
    else         abort_q <= abort;
  end
  assign abort_o = abort_q;
endmodule

// File: rtl/tx_start_seq_chk.sv
module tx_start_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_we_i,
  input logic       start_wdata_i,
  input logic       start_o,
  input logic [3:0] flag_clr_i,
  input logic [3:0] flags_o,
  input logic       wake_req_o,
  input logic       csma_go_o,
  input logic       tx_go_o,
  input logic       ack_listen_o,
  input logic       abort_o
);
  // R2
  launch_sets_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_we_i && start_wdata_i && !start_o |=> start_o);

  // R2
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csma_go_o || tx_go_o) |-> start_o);

  // R6
  listen_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_listen_o |-> start_o);

  // R10
  abort_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_we_i && !start_wdata_i && start_o |=> !start_o && abort_o);

  // R10
  abort_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_we_i && !start_wdata_i && start_o |=> (flags_o & ~$past(flags_o)) == 4'b0);

  // R11
  wake_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> !csma_go_o && !tx_go_o);

  // R12
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flags_o) & ~flags_o & ~$past(flag_clr_i)) == 4'b0));
endmodule

bind tx_start_seq tx_start_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_we_i    (start_we_i),
  .start_wdata_i (start_wdata_i),
  .start_o       (start_o),
  .flag_clr_i    (flag_clr_i),
  .flags_o       (flags_o),
  .wake_req_o    (wake_req_o),
  .csma_go_o     (csma_go_o),
  .tx_go_o       (tx_go_o),
  .ack_listen_o  (ack_listen_o),
  .abort_o       (abort_o)
);

// File: tb/tx_start_seq_bench.sv
module tx_start_seq_bench;
  localparam int RW = 3;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_we, start_wd, start_o;
  logic [3:0]    flag_clr, flags;
  logic          stream, csma_en, ack_req, auto_ack, rf_off;
  logic [RW-1:0] retry_limit;
  logic [TW-1:0] ack_timeout;
  logic          wake_req, csma_go, csma_done, csma_ok;
  logic          tx_go, tx_done, ack_listen, ack_rx, abort_p;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tx_start_seq #(.RETRY_W(RW), .TMO_W(TW)) u_tx_start_seq (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_we_i    (start_we),
    .start_wdata_i (start_wd),
    .start_o       (start_o),
    .flag_clr_i    (flag_clr),
    .flags_o       (flags),
    .stream_mode_i (stream),
    .csma_en_i     (csma_en),
    .ack_req_i     (ack_req),
    .auto_ack_en_i (auto_ack),
    .retry_limit_i (retry_limit),
    .ack_timeout_i (ack_timeout),
    .rf_off_i      (rf_off),
    .wake_req_o    (wake_req),
    .csma_go_o     (csma_go),
    .csma_done_i   (csma_done),
    .csma_ok_i     (csma_ok),
    .tx_go_o       (tx_go),
    .tx_done_i     (tx_done),
    .ack_listen_o  (ack_listen),
    .ack_rx_i      (ack_rx),
    .abort_o       (abort_p)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_flags();
    flag_clr = 4'hF;
    step();
    flag_clr = 4'h0;
  endtask

  task automatic write_start(input logic v);
    start_we = 1'b1;
    start_wd = v;
    step();
    start_we = 1'b0;
  endtask

  // one operation through channel access, send and acknowledgement wait
  task automatic run_op(input bit ce, input bit cok, input bit ae,
                        input int lim, input int ack_at, input int tmo);
    int sends;
    csma_en = ce; ack_req = ae; auto_ack = 1'b1; stream = 1'b0;
    retry_limit = RW'(lim); ack_timeout = TW'(tmo);
    clear_flags();
    write_start(1'b1);
    check("R2 start after write", int'(start_o), 1);
    sends = 0;
    for (int a = 0; a <= lim; a++) begin
      if (ce) begin
        check("R2 csma strobe", int'({csma_go, tx_go}), 2);
        csma_done = 1'b1; csma_ok = cok;
        step();
        csma_done = 1'b0;
        if (!cok) begin
          check("R5 start", int'(start_o), 0);
          check("R5 flags", int'(flags), 4);
          check("R5 no send", int'(tx_go), 0);
          return;
        end
      end
      check("R3 send strobe", int'({csma_go, tx_go}), 1);
      sends++;
      tx_done = 1'b1;
      step();
      tx_done = 1'b0;
      if (!ae) begin
        check("R4 start", int'(start_o), 0);
        check("R4 flags", int'(flags), 3);
        return;
      end
      check("R6 listen", int'(ack_listen), 1);
      if (a == ack_at) begin
        ack_rx = 1'b1;
        step();
        ack_rx = 1'b0;
        check("R6 ack success start", int'(start_o), 0);
        check("R6 ack success flags", int'(flags), 3);
        return;
      end
      repeat ((tmo > 1 ? tmo : 1) - 1) step();
      check("R7 still waiting", int'(ack_listen), 1);
      step();
      check("R7 wait ended", int'(ack_listen), 0);
    end
    check("R7 sends", sends, lim + 1);
    check("R7 start", int'(start_o), 0);
    check("R7 flags", int'(flags), 8);
  endtask

  task automatic abort_in(input int p);
    stream = 1'b1; csma_en = (p == 1); ack_req = (p == 3); auto_ack = 1'b1;
    rf_off = (p == 0); ack_timeout = 8'd20; retry_limit = 3'd0;
    clear_flags();
    write_start(1'b1);
    if (p != 0) write_start(1'b1);
    if (p == 3) begin
      tx_done = 1'b1;
      step();
      tx_done = 1'b0;
      check("R10 in ack wait", int'(ack_listen), 1);
    end
    if (p == 0) check("R10 in wake", int'(wake_req), 1);
    write_start(1'b0);
    check("R10 start cleared", int'(start_o), 0);
    check("R10 abort pulse", int'(abort_p), 1);
    check("R10 no flag", int'(flags), 0);
    check("R10 phase left", int'({wake_req, ack_listen}), 0);
    rf_off = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R10 no strobe after abort", int'({csma_go, tx_go, start_o}), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start_we = 0; start_wd = 0; flag_clr = 0; stream = 0; csma_en = 0;
    ack_req = 0; auto_ack = 0; rf_off = 0; retry_limit = 0; ack_timeout = 1;
    csma_done = 0; csma_ok = 0; tx_done = 0; ack_rx = 0;
    repeat (3) step();
    check("R1 reset outputs",
          int'({start_o, flags, wake_req, csma_go, tx_go, ack_listen, abort_p}), 0);
    rst_n = 1'b1;
    step();
    check("R1 after release", int'({start_o, flags}), 0);

    // sweep: channel access on/off, ack on/off, retry limit, ack arrival, timeout
    for (int ce = 0; ce < 2; ce++)
      for (int ae = 0; ae < 2; ae++)
        for (int lim = 0; lim < 3; lim++)
          for (int at = -1; at <= lim; at++)
            for (int t = 0; t < 4; t += 3)
              run_op(ce[0], 1'b1, ae[0], lim, at, t);
    run_op(1'b1, 1'b0, 1'b0, 0, -1, 1);
    run_op(1'b1, 1'b0, 1'b1, 2, -1, 1);

    // R8 queued start with retry count reset
    stream = 1; csma_en = 0; ack_req = 1; auto_ack = 1;
    retry_limit = 3'd1; ack_timeout = 8'd2;
    clear_flags();
    write_start(1'b1);
    tx_done = 1; step(); tx_done = 0;
    write_start(1'b1);
    step();
    check("R7 resend", int'(tx_go), 1);
    tx_done = 1; step(); tx_done = 0;
    ack_rx = 1; step(); ack_rx = 0;
    check("R8 start kept", int'(start_o), 1);
    check("R8 done not idle", int'(flags), 1);
    check("R8 restart strobe", int'(tx_go), 1);
    tx_done = 1; step(); tx_done = 0;
    step(); step();
    check("R8 retry count reset", int'(tx_go), 1);
    tx_done = 1; step(); tx_done = 0;
    step(); step();
    check("R8 final ack fail", int'({start_o, flags}), 9);

    // R9 ignored write outside streaming
    stream = 0; ack_req = 0;
    clear_flags();
    write_start(1'b1);
    write_start(1'b1);
    tx_done = 1; step(); tx_done = 0;
    check("R9 start cleared", int'(start_o), 0);
    check("R9 flags", int'(flags), 3);

    // R10 abort in each phase
    for (int p = 0; p < 4; p++) abort_in(p);

    // R11 wake from rf off
    stream = 0; csma_en = 1; ack_req = 0; rf_off = 1;
    clear_flags();
    write_start(1'b1);
    check("R11 wake request", int'(wake_req), 1);
    repeat (3) step();
    check("R11 held", int'({wake_req, csma_go, tx_go}), 4);
    rf_off = 0;
    step();
    check("R11 released", int'({wake_req, csma_go}), 1);
    csma_done = 1; csma_ok = 1; step(); csma_done = 0;
    tx_done = 1; step(); tx_done = 0;
    check("R11 op finished", int'({start_o, flags}), 3);

    // R12 set beats clear, per-bit clear
    csma_en = 0;
    clear_flags();
    write_start(1'b1);
    tx_done = 1; flag_clr = 4'hF; step(); tx_done = 0; flag_clr = 0;
    check("R12 set wins", int'(flags), 3);
    flag_clr = 4'h1; step(); flag_clr = 0;
    check("R12 single clear", int'(flags), 2);
    step();
    check("R12 sticky", int'(flags), 2);

    // R13 same-cycle host write and finish
    stream = 1;
    clear_flags();
    write_start(1'b1);
    tx_done = 1; start_we = 1; start_wd = 1; step();
    tx_done = 0; start_we = 0;
    check("R13 write1 at finish start", int'(start_o), 1);
    check("R13 write1 at finish flags", int'(flags), 1);
    check("R13 write1 at finish strobe", int'(tx_go), 1);
    tx_done = 1; start_we = 1; start_wd = 0; step();
    tx_done = 0; start_we = 0;
    check("R13 abort wins start", int'(start_o), 0);
    check("R13 abort wins flags", int'(flags), 1);
    check("R13 abort pulse", int'(abort_p), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule